// File: doc/BRIEF.md
# Nibble Bus Register Interface

This block sits between an external host and the digit counters of a calendar clock. The host shares one 4-bit bus for both the address and the data. To access a digit, the host first raises an address strobe while the register number is on the bus. It then uses separate read and write level strobes to move a nibble to or from the selected digit. Every access is qualified by two chip-select inputs, and both must be high.

The block does not store digits itself. On a write it gives the counter chain a one-hot write enable and a masked data nibble. On a read it selects one nibble from the flattened digit vector that the counters return, masks that nibble, and drives it out with an output enable. The bus pad uses the enable to turn its driver on. Outside a qualified read the enable is low and the output value is zero.

Top module: `nibble_bus_if`

## Requirements
- R1: A read or a write has an effect only while `csA` and `csB` are both high. A low `csA` blocks every access, whatever level `csB` has.
- R2: On a rising `clk` edge where both chip selects and `addrLatch` are high, `busIn[3:0]` is stored as the register address. Reads and writes in the same cycle still use the previously stored address.
- R3: The stored address holds until the next qualified address strobe, so several reads and writes can follow one address phase.
- R4: While a qualified `wrStrobe` is high and the address is in the range 0 to 12, `digWrEn` has only the bit of that address set, in the same cycle. `digWrData` carries the masked bus nibble. With no write, both outputs are zero.
- R5: While a qualified `rdStrobe` is high and `wrStrobe` is low, `busOe` is high. In the same cycle, `busOut` shows the addressed digit nibble, taken from `digitsIn[4*a+3:4*a]`.
- R6: Addresses 0 to 12 map, in order, to: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, weekday, day units, day tens, month units, month tens, year units and year tens.
- R7: Addresses 13, 14 and 15 read as 0000 with `busOe` high. A write to them raises no bit of `digWrEn`.
- R8: If `wrStrobe` and `rdStrobe` are high together, the write is performed and `busOe` stays low.
- R9: Each digit has a valid width, counted from bit 0. Seconds tens, minutes tens and weekday have 3 bits. Hours tens and day tens have 2 bits. Month tens has 1 bit. All other digits have 4 bits. Bits above the valid width read as zero and are forced to zero in `digWrData`.
- R10: While no qualified read is in progress, `busOe` is low and `busOut` is 0000.
- R11: While `rstN` is low, the stored address is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csA | input | 1 | Primary chip select; when low, it blocks all access |
| csB | input | 1 | Secondary chip select |
| addrLatch | input | 1 | Address strobe; stores the bus nibble as the address |
| wrStrobe | input | 1 | Write level strobe |
| rdStrobe | input | 1 | Read level strobe |
| busIn | input | 4 | Nibble received from the shared bus |
| busOut | output | 4 | Nibble to drive onto the shared bus |
| busOe | output | 1 | Bus driver enable |
| digitsIn | input | 52 | Digit values from the counter chain; nibble i belongs to address i |
| digWrEn | output | 13 | One-hot write enable, one bit per digit |
| digWrData | output | 4 | Masked write nibble sent to the counter chain |

## Verification
Three pairs of functions can fall in the same cycle.

- **Read and write.** The bench raises both strobes together on several addresses. It then expects the write enable and the masked data, and expects the bus to stay released.
- **Address strobe with a data strobe.** The bench raises the address strobe alongside a data strobe. It checks that this cycle's access still uses the old address, and that the new address takes effect one edge later.
- **Chip selects with any access.** Each of these pairings is repeated with one chip select low, and the bench expects no effect at all.

A queue-based scoreboard judges every step against values computed from the width table and map order.

// File: rtl/nbi_pkg.sv
package nbi_pkg;
  localparam int DATA_W = 4;

  typedef struct packed {
    logic latchAddr;
    logic wrEn;
    logic rdEn;
  } nbi_strobe_t;

  // Valid bit count of each digit position, counted from bit 0
  function automatic int digitWidth(input int idx);
    case (idx)
      1, 3, 6: digitWidth = 3;
      5, 8:    digitWidth = 2;
      10:      digitWidth = 1;
      default: digitWidth = DATA_W;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] digitMask(input int idx);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++)
      if (b < digitWidth(idx)) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/nbi_ctrl.sv
module nbi_ctrl
  import nbi_pkg::*;
(
  input  logic        csA,
  input  logic        csB,
  input  logic        addrLatch,
  input  logic        wrStrobe,
  input  logic        rdStrobe,
  output nbi_strobe_t strobes
);
  logic selected;

  // Primary select gates everything; secondary only adds a qualifier
  assign selected = csA & csB;

  always_comb begin
    strobes.latchAddr = selected & addrLatch;
    strobes.wrEn      = selected & wrStrobe;
    // a write wins over a simultaneous read
    strobes.rdEn      = selected & rdStrobe & ~wrStrobe;
  end
endmodule

// File: rtl/nbi_datapath.sv
module nbi_datapath
  import nbi_pkg::*;
#(
  parameter int NUM_DIGITS = 13,
  parameter int ADDR_W     = 4,
  localparam int BUS_W     = NUM_DIGITS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  nbi_strobe_t       strobes,
  input  logic [DATA_W-1:0] busIn,
  input  logic [BUS_W-1:0]  digitsIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [NUM_DIGITS-1:0] digWrEn,
  output logic [DATA_W-1:0] digWrData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] digitArr [NUM_DIGITS];
  logic [DATA_W-1:0] rdNib;
  logic [DATA_W-1:0] wrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  addrQ <= '0;
    else if (strobes.latchAddr) addrQ <= busIn[ADDR_W-1:0];
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign digitArr[g] = digitsIn[g*DATA_W +: DATA_W];
    assign digWrEn[g]  = strobes.wrEn && (addrQ == ADDR_W'(g));
  end

  // Unmapped addresses leave mask and read nibble at zero
  always_comb begin
    rdNib  = '0;
    wrMask = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (addrQ == ADDR_W'(i)) begin
        rdNib  = digitArr[i] & digitMask(i);
        wrMask = digitMask(i);
      end
    end
  end

  assign busOe     = strobes.rdEn;
  assign busOut    = strobes.rdEn ? rdNib : '0;
  assign digWrData = strobes.wrEn ? (busIn & wrMask) : '0;

  assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.latchAddr)) |-> addrQ == $past(busIn[ADDR_W-1:0]));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobes.latchAddr)) |-> $stable(addrQ));

  assert_we_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(digWrEn));

  assert_special_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addrQ >= ADDR_W'(NUM_DIGITS)) |-> (digWrEn == '0));

  assert_write_beats_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (digWrEn != '0) |-> !busOe);
endmodule

// File: rtl/nibble_bus_if.sv
module nibble_bus_if
  import nbi_pkg::*;
#(
  parameter int NUM_DIGITS = 13,
  parameter int ADDR_W     = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         csA,
  input  logic                         csB,
  input  logic                         addrLatch,
  input  logic                         wrStrobe,
  input  logic                         rdStrobe,
  input  logic [3:0]                   busIn,
  output logic [3:0]                   busOut,
  output logic                         busOe,
  input  logic [NUM_DIGITS*4-1:0]      digitsIn,
  output logic [NUM_DIGITS-1:0]        digWrEn,
  output logic [3:0]                   digWrData
);
  nbi_strobe_t strobes;

  nbi_ctrl u_ctrl (
    .csA       (csA),
    .csB       (csB),
    .addrLatch (addrLatch),
    .wrStrobe  (wrStrobe),
    .rdStrobe  (rdStrobe),
    .strobes   (strobes)
  );

  nbi_datapath #(
    .NUM_DIGITS (NUM_DIGITS),
    .ADDR_W     (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busIn     (busIn),
    .digitsIn  (digitsIn),
    .busOut    (busOut),
    .busOe     (busOe),
    .digWrEn   (digWrEn),
    .digWrData (digWrData)
  );

  assert_cs_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(csA && csB) |-> (!busOe && digWrEn == '0 && digWrData == '0));

  assert_bus_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> busOut == '0);
endmodule

// File: tb/nibble_bus_if_test.sv
module nibble_bus_if_test;
  localparam int ND = 13;

  typedef struct {
    logic        oe;
    logic [3:0]  out;
    logic [12:0] we;
    logic [3:0]  wd;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csA = 0, csB = 0, addrLatch = 0, wrStrobe = 0, rdStrobe = 0;
  logic [3:0] busIn = '0;
  logic [3:0] busOut;
  logic busOe;
  logic [ND*4-1:0] digitsIn = '1;
  logic [ND-1:0] digWrEn;
  logic [3:0] digWrData;

  exp_t scoreQ[$];
  int tests = 0;
  int fails = 0;
  int addrModel = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nibble_bus_if uut (
    .clk(clk), .rstN(rstN), .csA(csA), .csB(csB), .addrLatch(addrLatch),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .digitsIn(digitsIn), .digWrEn(digWrEn), .digWrData(digWrData)
  );

  // R9 width table, written independently of the design
  function automatic logic [3:0] maskOf(input int a);
    int w;
    case (a)
      1, 3, 6: w = 3;
      5, 8:    w = 2;
      10:      w = 1;
      default: w = 4;
    endcase
    return 4'((1 << w) - 1);
  endfunction

  task automatic step(input logic ca, input logic cb, input logic lat,
                      input logic wr, input logic rd, input logic [3:0] d,
                      input string tag);
    exp_t e;
    logic sel;
    @(posedge clk);
    #1;
    csA = ca; csB = cb; addrLatch = lat; wrStrobe = wr; rdStrobe = rd; busIn = d;
    sel   = ca & cb;
    e.tag = tag;
    e.oe  = sel & rd & ~wr;
    e.out = (e.oe && addrModel < ND) ? (digitsIn[addrModel*4 +: 4] & maskOf(addrModel)) : 4'h0;
    e.we  = (sel && wr && addrModel < ND) ? 13'(1 << addrModel) : 13'h0;
    e.wd  = (sel && wr) ? ((addrModel < ND) ? (d & maskOf(addrModel)) : 4'h0) : 4'h0;
    scoreQ.push_back(e);
    if (sel && lat) addrModel = int'(d);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (scoreQ.size() > 0) begin
        e = scoreQ.pop_front();
        tests++;
        if (busOe !== e.oe || busOut !== e.out || digWrEn !== e.we || digWrData !== e.wd) begin
          fails++;
          $display("FAIL %s: got oe=%b out=%h we=%h wd=%h, expected oe=%b out=%h we=%h wd=%h",
                   e.tag, busOe, busOut, digWrEn, digWrData, e.oe, e.out, e.we, e.wd);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R11: address is 0 after reset, so seconds units reads back
    step(1, 1, 0, 0, 1, 4'h0, "R11 reset address");
    // R2 / R9: latch hours tens, read masked all-ones
    step(1, 1, 1, 0, 0, 4'h5, "R2 latch phase");
    step(1, 1, 0, 0, 1, 4'h0, "R2 R9 read hours tens");
    step(1, 1, 0, 0, 1, 4'h0, "R3 second read");
    step(1, 1, 0, 1, 0, 4'hF, "R4 R9 write masked");
    // R1: blocked latch and accesses
    step(0, 1, 1, 0, 0, 4'h2, "R1 latch blocked csA low");
    step(1, 1, 0, 0, 1, 4'h0, "R1 R3 address kept");
    step(0, 1, 0, 0, 1, 4'h0, "R1 read blocked csA low");
    step(1, 0, 0, 1, 0, 4'h7, "R1 write blocked csB low");
    step(0, 0, 0, 1, 1, 4'h7, "R1 both selects low");
    // R8 collision
    step(1, 1, 0, 1, 1, 4'h6, "R8 write wins");
    // R2: latch with simultaneous read uses old address
    step(1, 1, 1, 0, 1, 4'h3, "R2 latch with read uses old");
    step(1, 1, 0, 0, 1, 4'h0, "R2 new address active");
    step(1, 1, 1, 1, 0, 4'hA, "R2 latch with write uses old");
    step(1, 1, 0, 0, 0, 4'h0, "R10 idle");
    // R6 / R7 / R9 sweep over every address
    for (int a = 0; a < 16; a++) begin
      step(1, 1, 1, 0, 0, 4'(a), "R6 latch sweep");
      step(1, 1, 0, 0, 1, 4'h0, "R6 R7 R9 read sweep");
      step(1, 1, 0, 1, 0, 4'hF, "R4 R7 R9 write sweep");
      step(1, 1, 0, 1, 1, 4'h9, "R8 collision sweep");
    end
    // R5 / R6: distinct pattern per digit
    @(posedge clk);
    #1;
    for (int i = 0; i < ND; i++) digitsIn[i*4 +: 4] = 4'((i * 7 + 3) & 15);
    for (int a = 0; a < ND; a++) begin
      step(1, 1, 1, 0, 0, 4'(a), "R5 latch pattern");
      step(1, 1, 0, 0, 1, 4'h0, "R5 R6 read pattern");
      step(0, 1, 0, 0, 1, 4'h0, "R10 released");
    end
    step(1, 1, 0, 0, 0, 4'h0, "R10 final idle");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule